// File: doc/BRIEF.md
# Context-Tagged Translation Buffer with Scoped Invalidation

This block is a small fully associative translation buffer. It holds leaf translation entries, each tagged with a context number, a virtual tag and the table level at which the mapping was found. A lookup port answers in the same cycle with a hit flag and the stored 32-bit leaf entry. A table walker outside the block supplies new entries through a refill port.

A maintenance port serves software. A maintenance write carries a scope code in address bits [11:8] and invalidates a page, a segment, a region, a whole context or every entry. A maintenance read with scope code 4 is a probe: it returns the cached leaf entry for the current context and the page address, or zero. The walk itself, permission checks and data cache upkeep belong to other blocks.

Top module: `tlb_core`

## Requirements
- R1: After reset no entry is valid: every lookup misses and every probe returns 0.
- R2: A refill with level code 1 (region), 2 (segment) or 3 (page) installs an entry. From the next cycle, a lookup with the same context and the refill address hits and returns the refilled leaf entry. A refill with level code 0 is ignored.
- R3: A lookup hits only when the context is equal and the virtual address agrees on the bits the entry's level covers: [31:24] for region, [31:18] for segment, [31:12] for page.
- R4: On a miss `lk_hit` is 0 and `lk_pte` is 0.
- R5: A refill whose context and address already hit a stored entry rewrites that entry in place. This includes new modified and referenced bits and the new page field [31:8]. No further slot is allocated.
- R6: There are 8 slots, filled in round-robin order. When all are in use, the next new allocation evicts the oldest allocated entry.
- R7: A maintenance write with scope code 4 in bits [11:8] invalidates every entry.
- R8: Scope code 3 invalidates exactly the entries whose context equals `cur_ctx`.
- R9: Scope code 2 invalidates entries of context `cur_ctx` whose address bits [31:24] equal those of the write address.
- R10: Scope code 1 (address bits [31:18]) and scope code 0 (bits [31:12]) invalidate matching entries in any context. The comparison uses the coarser of the scope and the entry's level, so a region entry covering a flushed page is also removed.
- R11: Maintenance writes with scope codes 5 to 15 change no entry.
- R12: When a valid flush and a refill arrive in the same cycle, the flush is applied and the refill is discarded.
- R13: A maintenance read with code 4 returns the leaf entry that a lookup with `cur_ctx` and `mt_addr` would return, or 0 on a miss. A read with any other code returns 0, and `mt_rdata` is 0 whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_ctx | input | CTX_W | Context of the lookup |
| lk_va | input | 32 | Virtual address of the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_pte | output | 32 | Leaf entry on hit, 0 on miss |
| fill_valid | input | 1 | Refill request from the walker |
| fill_ctx | input | CTX_W | Context of the refill |
| fill_va | input | 32 | Virtual address of the refill |
| fill_level | input | 2 | Level code of the mapping (0 none, 1 region, 2 segment, 3 page) |
| fill_pte | input | 32 | Leaf entry to store |
| cur_ctx | input | CTX_W | Current context for scoped flushes and probes |
| mt_wr | input | 1 | Maintenance write (flush) |
| mt_rd | input | 1 | Maintenance read (probe) |
| mt_addr | input | 32 | Maintenance address; bits [11:8] hold the scope code |
| mt_rdata | output | 32 | Probe result |

## Verification
The bench builds the block with its defaults, 8 slots and an 8-bit context. The random stimulus draws contexts from only four values and addresses from two regions, each with three segments and three pages. As a result, cross-context aliasing, overlapping levels, in-place refills and eviction after wraparound all happen within a few dozen operations. The small slot count also lets directed cases wrap the round-robin pointer and observe the eviction directly.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W         = 32;
    localparam int PG_LSB       = 12;
    localparam int TAG_W        = VA_W - PG_LSB;
    localparam int PTE_W        = 32;
    localparam int CODE_LSB     = 8;
    localparam int CODE_W       = 4;
    localparam int REGION_BITS  = 8;
    localparam int SEGMENT_BITS = 14;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [PTE_W-1:0] pte_t;

    // Table level at which a leaf mapping was found
    typedef enum logic [1:0] {
        LV_NONE    = 2'd0,
        LV_REGION  = 2'd1,
        LV_SEGMENT = 2'd2,
        LV_PAGE    = 2'd3
    } lvl_e;

    // Scope codes carried in maintenance address bits [11:8]
    typedef enum logic [CODE_W-1:0] {
        SC_PAGE    = 4'h0,
        SC_SEGMENT = 4'h1,
        SC_REGION  = 4'h2,
        SC_CONTEXT = 4'h3,
        SC_ALL     = 4'h4
    } scope_e;

    typedef struct packed {
        tag_t tag;
        lvl_e lvl;
        pte_t pte;
    } ent_t;

    localparam tag_t M_REGION  = tag_t'({REGION_BITS{1'b1}})  << (TAG_W - REGION_BITS);
    localparam tag_t M_SEGMENT = tag_t'({SEGMENT_BITS{1'b1}}) << (TAG_W - SEGMENT_BITS);
    localparam tag_t M_PAGE    = '1;

    // Tag bits a mapping of the given level covers
    function automatic tag_t lvl_mask(lvl_e l);
        case (l)
            LV_REGION:  return M_REGION;
            LV_SEGMENT: return M_SEGMENT;
            LV_PAGE:    return M_PAGE;
            default:    return '0;
        endcase
    endfunction

    // Tag bits an address-scoped flush compares
    function automatic tag_t scope_mask(scope_e s);
        case (s)
            SC_PAGE:    return M_PAGE;
            SC_SEGMENT: return M_SEGMENT;
            default:    return M_REGION;
        endcase
    endfunction

    function automatic logic scope_ok(logic [CODE_W-1:0] code);
        return code <= CODE_W'(SC_ALL);
    endfunction

endpackage

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter int N_ENT = 8,
    localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] ptr
);

    // Round-robin victim pointer, advances on each new allocation
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == IW'(N_ENT - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int CTX_W = 8,
    localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] valid,
    input  logic [CTX_W-1:0] ctx   [N_ENT],
    input  ent_t             ents  [N_ENT],
    input  logic [CTX_W-1:0] q_ctx,
    input  tag_t             q_tag,
    output logic             any,
    output logic [IW-1:0]    idx,
    output pte_t             pte
);

    logic [N_ENT-1:0] hit_vec;

    // One comparator per slot, masked by the slot's own level
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (ctx[g] == q_ctx) &&
                            (((ents[g].tag ^ q_tag) & lvl_mask(ents[g].lvl)) == '0);
    end

    // Lowest-numbered matching slot wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    assign pte = any ? ents[idx].pte : '0;

endmodule

// File: rtl/tlb_flush_dec.sv
module tlb_flush_dec
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int CTX_W = 8
) (
    input  logic               en,
    input  logic [CODE_W-1:0]  code,
    input  tag_t               a_tag,
    input  logic [CTX_W-1:0]   cur_ctx,
    input  logic [N_ENT-1:0]   valid,
    input  logic [CTX_W-1:0]   ctx  [N_ENT],
    input  tag_t               tags [N_ENT],
    input  lvl_e               lvls [N_ENT],
    output logic [N_ENT-1:0]   kill
);

    scope_e sc;
    tag_t   sc_mask;

    assign sc      = scope_e'(code);
    assign sc_mask = scope_mask(sc);

    for (genvar g = 0; g < N_ENT; g++) begin : g_kill
        tag_t cmp;
        logic va_ok;
        logic ctx_ok;
        logic sel;

        // Compare at the coarser of the flush scope and the entry level
        assign cmp    = sc_mask & lvl_mask(lvls[g]);
        assign va_ok  = ((tags[g] ^ a_tag) & cmp) == '0;
        assign ctx_ok = ctx[g] == cur_ctx;

        always_comb begin
            case (sc)
                SC_PAGE, SC_SEGMENT: sel = va_ok;
                SC_REGION:           sel = va_ok && ctx_ok;
                SC_CONTEXT:          sel = ctx_ok;
                SC_ALL:              sel = 1'b1;
                default:             sel = 1'b0;
            endcase
        end

        assign kill[g] = en && valid[g] && sel;
    end

endmodule

// File: rtl/tlb_core.sv
module tlb_core
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTX_W-1:0] lk_ctx,
    input  logic [31:0]      lk_va,
    output logic             lk_hit,
    output logic [31:0]      lk_pte,
    input  logic             fill_valid,
    input  logic [CTX_W-1:0] fill_ctx,
    input  logic [31:0]      fill_va,
    input  logic [1:0]       fill_level,
    input  logic [31:0]      fill_pte,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic             mt_wr,
    input  logic             mt_rd,
    input  logic [31:0]      mt_addr,
    output logic [31:0]      mt_rdata
);

    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    // Storage
    logic [N_ENT-1:0] valid_q;
    logic [CTX_W-1:0] ctx_q [N_ENT];
    ent_t             ent_q [N_ENT];
    tag_t             tag_w [N_ENT];
    lvl_e             lvl_w [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_view
        assign tag_w[g] = ent_q[g].tag;
        assign lvl_w[g] = ent_q[g].lvl;
    end

    logic [CODE_W-1:0] mt_code;
    assign mt_code = mt_addr[CODE_LSB +: CODE_W];

    // Lookup port
    logic          lk_any;
    logic [IW-1:0] lk_idx;
    pte_t          lk_ent;

    tlb_match #(.N_ENT(N_ENT), .CTX_W(CTX_W)) u_lk_match (
        .valid (valid_q),
        .ctx   (ctx_q),
        .ents  (ent_q),
        .q_ctx (lk_ctx),
        .q_tag (lk_va[VA_W-1:PG_LSB]),
        .any   (lk_any),
        .idx   (lk_idx),
        .pte   (lk_ent)
    );

    assign lk_hit = lk_any;
    assign lk_pte = lk_ent;

    // Probe on the maintenance port, in the current context
    logic          pb_any;
    logic [IW-1:0] pb_idx;
    pte_t          pb_ent;

    tlb_match #(.N_ENT(N_ENT), .CTX_W(CTX_W)) u_pb_match (
        .valid (valid_q),
        .ctx   (ctx_q),
        .ents  (ent_q),
        .q_ctx (cur_ctx),
        .q_tag (mt_addr[VA_W-1:PG_LSB]),
        .any   (pb_any),
        .idx   (pb_idx),
        .pte   (pb_ent)
    );

    assign mt_rdata = (mt_rd && (mt_code == CODE_W'(SC_ALL))) ? pb_ent : '0;

    // Refill search for an entry to rewrite in place
    logic          fm_any;
    logic [IW-1:0] fm_idx;
    pte_t          fm_ent;

    tlb_match #(.N_ENT(N_ENT), .CTX_W(CTX_W)) u_fill_match (
        .valid (valid_q),
        .ctx   (ctx_q),
        .ents  (ent_q),
        .q_ctx (fill_ctx),
        .q_tag (fill_va[VA_W-1:PG_LSB]),
        .any   (fm_any),
        .idx   (fm_idx),
        .pte   (fm_ent)
    );

    // Flush decode
    logic             flush_en;
    logic [N_ENT-1:0] kill;

    assign flush_en = mt_wr && scope_ok(mt_code);

    tlb_flush_dec #(.N_ENT(N_ENT), .CTX_W(CTX_W)) u_flush (
        .en      (flush_en),
        .code    (mt_code),
        .a_tag   (mt_addr[VA_W-1:PG_LSB]),
        .cur_ctx (cur_ctx),
        .valid   (valid_q),
        .ctx     (ctx_q),
        .tags    (tag_w),
        .lvls    (lvl_w),
        .kill    (kill)
    );

    // Refill control: flush wins, level 0 is dropped
    lvl_e          fill_lvl;
    logic          fill_go;
    logic [IW-1:0] rr_ptr;
    logic [IW-1:0] wr_idx;
    ent_t          fill_ent;

    assign fill_lvl = lvl_e'(fill_level);
    assign fill_go  = fill_valid && (fill_lvl != LV_NONE) && !flush_en;
    assign wr_idx   = fm_any ? fm_idx : rr_ptr;
    assign fill_ent = '{tag: fill_va[VA_W-1:PG_LSB] & lvl_mask(fill_lvl),
                        lvl: fill_lvl,
                        pte: fill_pte};

    tlb_repl #(.N_ENT(N_ENT)) u_repl (
        .clk (clk),
        .rst (rst),
        .adv (fill_go && !fm_any),
        .ptr (rr_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (flush_en) begin
            valid_q <= valid_q & ~kill;
        end else if (fill_go) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_go) begin
            ctx_q[wr_idx] <= fill_ctx;
            ent_q[wr_idx] <= fill_ent;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{lk_va[PG_LSB-1:0], fill_va[PG_LSB-1:0], mt_addr[CODE_LSB-1:0],
                           lk_idx, pb_idx, fm_ent};

endmodule

// File: rtl/tlb_core_chk.sv
module tlb_core_chk #(
    parameter int CTX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CTX_W-1:0] lk_ctx,
    input logic [31:0]      lk_va,
    input logic             lk_hit,
    input logic [31:0]      lk_pte,
    input logic             fill_valid,
    input logic [CTX_W-1:0] fill_ctx,
    input logic [31:0]      fill_va,
    input logic [1:0]       fill_level,
    input logic [31:0]      fill_pte,
    input logic [CTX_W-1:0] cur_ctx,
    input logic             mt_wr,
    input logic             mt_rd,
    input logic [31:0]      mt_addr,
    input logic [31:0]      mt_rdata
);

    // R2
    refill_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fill_valid) && ($past(fill_level) != 2'd0) && !$past(mt_wr) &&
         (lk_ctx == $past(fill_ctx)) && (lk_va == $past(fill_va)))
        |-> (lk_hit && (lk_pte == $past(fill_pte))));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pte == 32'd0));

    // R7
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        (mt_wr && (mt_addr[11:8] == 4'h4)) |=> !lk_hit);

    // R12
    flush_over_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mt_wr && (mt_addr[11:8] == 4'h4) && fill_valid && (fill_level != 2'd0)) |=> !lk_hit);

    // R13
    probe_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!mt_rd || (mt_addr[11:8] != 4'h4)) |-> (mt_rdata == 32'd0));

    logic unused_chk;
    assign unused_chk = ^{cur_ctx, mt_addr};

endmodule

bind tlb_core tlb_core_chk #(.CTX_W(CTX_W)) u_chk (.*);

// File: tb/tlb_core_bench.sv
module tlb_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] lk_ctx = '0;
    logic [31:0]   lk_va = '0;
    logic          lk_hit;
    logic [31:0]   lk_pte;
    logic          fill_valid = 1'b0;
    logic [CW-1:0] fill_ctx = '0;
    logic [31:0]   fill_va = '0;
    logic [1:0]    fill_level = '0;
    logic [31:0]   fill_pte = '0;
    logic [CW-1:0] cur_ctx = '0;
    logic          mt_wr = 1'b0;
    logic          mt_rd = 1'b0;
    logic [31:0]   mt_addr = '0;
    logic [31:0]   mt_rdata;

    tlb_core #(.N_ENT(N), .CTX_W(CW)) u_tlb_core (
        .clk(clk), .rst(rst), .lk_ctx(lk_ctx), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pte(lk_pte),
        .fill_valid(fill_valid), .fill_ctx(fill_ctx), .fill_va(fill_va), .fill_level(fill_level),
        .fill_pte(fill_pte), .cur_ctx(cur_ctx), .mt_wr(mt_wr), .mt_rd(mt_rd), .mt_addr(mt_addr),
        .mt_rdata(mt_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model built from the requirements
    bit            m_v   [N];
    logic [CW-1:0] m_ctx [N];
    logic [31:0]   m_va  [N];
    int            m_lvl [N];
    logic [31:0]   m_pte [N];
    int            m_rr;

    function automatic logic [31:0] lmask(input int l);
        case (l)
            1:       return 32'hFF00_0000;
            2:       return 32'hFFFC_0000;
            3:       return 32'hFFFF_F000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic int m_find(input logic [CW-1:0] c, input logic [31:0] va);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_ctx[i] == c && ((m_va[i] ^ va) & lmask(m_lvl[i])) == 32'h0) return i;
        return -1;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_rr = 0;
    endfunction

    function automatic void m_fill(input logic [CW-1:0] c, input logic [31:0] va, input int l,
                                   input logic [31:0] p);
        int k;
        if (l == 0) return;
        k = m_find(c, va);
        if (k < 0) begin
            k = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_v[k] = 1'b1; m_ctx[k] = c; m_va[k] = va & lmask(l); m_lvl[k] = l; m_pte[k] = p;
    endfunction

    function automatic void m_flush(input logic [31:0] a, input logic [CW-1:0] cur);
        logic [31:0] sm;
        case (a[11:8])
            4'h0:    sm = 32'hFFFF_F000;
            4'h1:    sm = 32'hFFFC_0000;
            default: sm = 32'hFF00_0000;
        endcase
        for (int i = 0; i < N; i++) begin
            logic [31:0] cmp;
            bit va_ok, ctx_ok, k;
            cmp    = sm & lmask(m_lvl[i]);
            va_ok  = ((m_va[i] ^ a) & cmp) == 32'h0;
            ctx_ok = m_ctx[i] == cur;
            case (a[11:8])
                4'h0, 4'h1: k = va_ok;
                4'h2:       k = va_ok && ctx_ok;
                4'h3:       k = ctx_ok;
                4'h4:       k = 1'b1;
                default:    k = 1'b0;
            endcase
            if (m_v[i] && k) m_v[i] = 1'b0;
        end
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [31:0] addr, input logic [CW-1:0] cur,
                         input bit fv, input logic [CW-1:0] fc, input logic [31:0] fva,
                         input int fl, input logic [31:0] fp);
        @(negedge clk);
        mt_wr = wr; mt_addr = addr; cur_ctx = cur;
        fill_valid = fv; fill_ctx = fc; fill_va = fva; fill_level = 2'(fl); fill_pte = fp;
        @(posedge clk);
        if (wr && addr[11:8] <= 4'h4) m_flush(addr, cur);
        else if (fv) m_fill(fc, fva, fl, fp);
        #1;
        mt_wr = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic fill(input logic [CW-1:0] c, input logic [31:0] va, input int l,
                        input logic [31:0] p);
        do_op(1'b0, 32'h0, '0, 1'b1, c, va, l, p);
    endtask

    task automatic flush(input logic [31:0] a, input logic [CW-1:0] cur);
        do_op(1'b1, a, cur, 1'b0, '0, 32'h0, 0, 32'h0);
    endtask

    task automatic chk_lookup(input string req, input logic [CW-1:0] c, input logic [31:0] va);
        int k;
        @(negedge clk);
        lk_ctx = c; lk_va = va;
        #1;
        k = m_find(c, va);
        check(req, "hit", {31'd0, lk_hit}, (k >= 0) ? 32'd1 : 32'd0);
        check(req, "pte", lk_pte, (k >= 0) ? m_pte[k] : 32'd0);
    endtask

    task automatic chk_probe(input string req, input logic [CW-1:0] cur, input logic [31:0] a);
        int k;
        logic [31:0] exp;
        @(negedge clk);
        cur_ctx = cur; mt_addr = a; mt_rd = 1'b1;
        #1;
        k = m_find(cur, a);
        exp = (a[11:8] == 4'h4 && k >= 0) ? m_pte[k] : 32'h0;
        check(req, "probe", mt_rdata, exp);
        mt_rd = 1'b0;
    endtask

    function automatic logic [31:0] rnd_va();
        return {8'h40 + 8'($urandom % 2), 6'($urandom % 3), 6'($urandom % 3), 12'($urandom)};
    endfunction

    function automatic void summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk_lookup("R1", 8'd0, 32'h0000_0000);
        chk_probe("R1", 8'd0, 32'h0000_0400);

        // R2 / R3 / R4 page entry
        fill(8'd1, 32'h4012_3000, 3, 32'h1234_5682);
        chk_lookup("R2", 8'd1, 32'h4012_3ABC);
        chk_lookup("R3", 8'd2, 32'h4012_3ABC);
        chk_lookup("R4", 8'd1, 32'h4012_4000);

        // R3 region and segment granularity
        fill(8'd1, 32'h5500_0000, 1, 32'h0AAA_AA02);
        chk_lookup("R3", 8'd1, 32'h55FF_F123);
        chk_lookup("R3", 8'd1, 32'h5600_0000);
        fill(8'd1, 32'h6004_0000, 2, 32'h0BBB_BB02);
        chk_lookup("R3", 8'd1, 32'h6007_F000);
        chk_lookup("R3", 8'd1, 32'h6008_0000);

        // R2 level code 0 ignored
        fill(8'd1, 32'h7000_0000, 0, 32'h0CCC_CC02);
        chk_lookup("R2", 8'd1, 32'h7000_0000);

        // R5 in-place refill with modified/referenced bits and new page field
        fill(8'd1, 32'h4012_3000, 3, 32'h9876_54E2);
        chk_lookup("R5", 8'd1, 32'h4012_3000);

        // R13 probe
        chk_probe("R13", 8'd1, 32'h4012_3400);
        chk_probe("R13", 8'd1, 32'h4012_3300);
        chk_probe("R13", 8'd2, 32'h4012_3400);

        // R11 unused scope codes
        flush(32'h4012_3500, 8'd1);
        flush(32'h4012_3F00, 8'd1);
        chk_lookup("R11", 8'd1, 32'h4012_3000);

        // R10 page scope across contexts and over a covering region entry
        fill(8'd2, 32'h4012_3000, 3, 32'h1111_1102);
        flush(32'h4012_3000, 8'd3);
        chk_lookup("R10", 8'd1, 32'h4012_3000);
        chk_lookup("R10", 8'd2, 32'h4012_3000);
        flush(32'h55AB_C000, 8'd3);
        chk_lookup("R10", 8'd1, 32'h5500_0000);
        chk_lookup("R10", 8'd1, 32'h6004_0000);
        flush(32'h6005_0100, 8'd3);
        chk_lookup("R10", 8'd1, 32'h6004_0000);

        // R9 region scope limited to current context
        fill(8'd1, 32'h4A00_1000, 3, 32'h2222_2202);
        fill(8'd2, 32'h4A00_2000, 3, 32'h3333_3302);
        flush(32'h4A00_0200, 8'd1);
        chk_lookup("R9", 8'd1, 32'h4A00_1000);
        chk_lookup("R9", 8'd2, 32'h4A00_2000);

        // R8 context scope
        fill(8'd5, 32'h3000_0000, 3, 32'h4444_4402);
        fill(8'd5, 32'h3100_0000, 1, 32'h5555_5502);
        fill(8'd6, 32'h3000_0000, 3, 32'h6666_6602);
        flush(32'h0000_0300, 8'd5);
        chk_lookup("R8", 8'd5, 32'h3000_0000);
        chk_lookup("R8", 8'd5, 32'h3100_0000);
        chk_lookup("R8", 8'd6, 32'h3000_0000);

        // R7 flush everything
        flush(32'h0000_0400, 8'd0);
        chk_lookup("R7", 8'd6, 32'h3000_0000);
        chk_lookup("R7", 8'd2, 32'h4A00_2000);

        // R6 round robin eviction after wraparound
        for (int i = 0; i < N + 1; i++)
            fill(8'd0, 32'h1000_0000 + (i << 12), 3, 32'h0100_0002 + (i << 8));
        for (int i = 0; i < N + 1; i++)
            chk_lookup("R6", 8'd0, 32'h1000_0000 + (i << 12));

        // R12 flush beats refill; an unused code lets the refill through
        do_op(1'b1, 32'h0000_0400, 8'd0, 1'b1, 8'd0, 32'h2000_0000, 3, 32'h7777_7702);
        chk_lookup("R12", 8'd0, 32'h2000_0000);
        do_op(1'b1, 32'h0000_0700, 8'd0, 1'b1, 8'd0, 32'h2000_0000, 3, 32'h7777_7702);
        chk_lookup("R12", 8'd0, 32'h2000_0000);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [31:0] a;
            op = int'($urandom % 10);
            a  = rnd_va();
            case (op)
                0, 1, 2, 3: fill(CW'($urandom % 4), a, int'($urandom % 4), $urandom);
                4, 5, 9:    chk_lookup("R3", CW'($urandom % 4), a);
                6:          chk_probe("R13", CW'($urandom % 4),
                                      {a[31:12], ($urandom % 3 == 0) ? 4'h2 : 4'h4, 8'h0});
                7:          flush({a[31:12], 4'($urandom % 6), 8'h0}, CW'($urandom % 4));
                default:    do_op(1'b1, {a[31:12], 4'($urandom % 6), 8'h0}, CW'($urandom % 4),
                                  1'b1, CW'($urandom % 4), rnd_va(), int'($urandom % 4), $urandom);
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule